// File: doc/BRIEF.md
# Dual-Bank Interrupt Line Controller

This block gathers 32 interrupt request lines and presents them to a processor through two independent banks of configuration and status registers. One bank drives a normal interrupt request output, the other drives a fast interrupt request output. Both banks watch the same 32 lines. Each bank decides for itself, line by line, whether a line counts as pending and whether it may reach that bank's output.

Each line in a bank is configured with a sense-select bit and a sense-polarity bit. In level sense, the pending state follows the input directly, with either active-high or active-low polarity. In edge sense, a chosen transition of the input sets a sticky latch. Software removes the latch by writing a one to that line's bit in the bank's acknowledge register. An enable word gates the pending bits into a status word. The registered OR of the status word is the bank's output. Software reads the status word, services the lowest set bit, acknowledges it and reads again until the status word is zero.

The register port is a flat 32-bit word interface decoded by byte offset. Reads are combinational and have no side effects. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, the enable, sense-select and polarity words of both banks read 0, every edge latch is clear, and both request outputs are 0.
- R2: Byte offsets within a bank are: 0x00 raw pending (read only), 0x04 enable, 0x08 acknowledge (write only, reads 0), 0x0C sense-select, 0x10 polarity and 0x14 status (read only). The normal bank's offsets start at 0x00 and the fast bank's at 0x20. Any other offset, and any offset that is not word-aligned, reads 0, and writes to it change nothing. Writes to a read-only register change nothing.
- R3: Bit i of every register belongs to line i. Status equals raw pending AND enable, where an enable bit of 1 admits the line. Writing 0 to the enable word silences the bank, and the raw pending word stays unmasked.
- R4: With sense-select 0, a line is level sensed. Polarity 0 makes it pending while the input is 1, and polarity 1 makes it pending while the input is 0. Level lines are not latched, so the pending bit follows the input combinationally.
- R5: With sense-select 1, a line is edge sensed. Polarity 1 selects a 0-to-1 transition and polarity 0 selects a 1-to-0 transition. The transition is judged between the input values sampled on two consecutive clock edges. The pending bit is visible after the edge that samples the new value, and it stays set after the input returns.
- R6: An acknowledge write clears the edge latch of every line whose written bit is 1. Lines whose bit is 0 are untouched, and the write has no effect on level-sensed lines.
- R7: If a selected transition and an acknowledge of the same line fall on the same clock edge, the latch ends up set.
- R8: Each request output is registered. It equals the OR of its bank's status word as it stood just before the previous clock edge.
- R9: The two banks are independent. A write to one bank never changes the other bank's registers or output.
- R10: Setting a line to level sense discards its edge latch. A later return to edge sense starts with the latch clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 32 | Interrupt request lines |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_req | output | 1 | Normal-bank request, registered |
| fiq_req | output | 1 | Fast-bank request, registered |

## Verification
The bench targets the places where a plausible design goes quietly wrong.
- An edge and an acknowledge on the same clock: a design that gives the acknowledge priority drops an interrupt.
- An acknowledge word with unrelated bits set: a design that clears the whole latch loses pending edges.
- Level lines under an acknowledge: a design that latches them keeps the request up after the input falls.
- The transition direction: a design with the polarity inverted fires on the wrong edge.
- A round trip through level sense: a design that keeps the edge latch across it replays a stale event.
- Misaligned, out-of-range and read-only writes: a design with loose decode aliases them onto the enable word or onto the other bank.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [2:0] {
    REG_SRC  = 3'd0,
    REG_MASK = 3'd1,
    REG_CLR  = 3'd2,
    REG_MODE = 3'd3,
    REG_POL  = 3'd4,
    REG_STS  = 3'd5
  } reg_sel_e;

  localparam int unsigned REG_LAST   = 5;
  localparam int unsigned BANK_COUNT = 2;
  localparam int unsigned BANK_NORM  = 0;
  localparam int unsigned BANK_FAST  = 1;

  // Selected transition between the previous and the current sample.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic rise);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Level activity, polarity 1 inverts the input.
  function automatic logic level_hit(input logic cur, input logic low_active);
    return cur ^ low_active;
  endfunction

  // Next value of an edge latch: a new event beats an acknowledge.
  function automatic logic latch_next(input logic held, input logic edge_mode,
                                      input logic ack, input logic evt);
    return edge_mode & ((held & ~ack) | evt);
  endfunction

endpackage

// File: rtl/intc_sampler.sv
module intc_sampler #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_LINES-1:0] prev_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= line_in;
  end

endmodule

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BANK_SPAN = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              bank,
  output reg_sel_e          sel
);

  localparam int unsigned WORD_LSB = 2;
  localparam int unsigned SPAN_LSB = $clog2(BANK_SPAN);
  localparam int unsigned SEL_W    = SPAN_LSB - WORD_LSB;

  logic [ADDR_W-1:0] blk;
  logic [SEL_W-1:0]  idx;
  logic              aligned;
  logic              in_range;

  always_comb begin
    blk      = addr >> SPAN_LSB;
    idx      = addr[SPAN_LSB-1:WORD_LSB];
    aligned  = (addr[WORD_LSB-1:0] == '0);
    in_range = (blk < ADDR_W'(BANK_COUNT)) && (idx <= SEL_W'(REG_LAST));
    hit      = aligned && in_range;
    bank     = blk[0];
    sel      = reg_sel_e'(idx);
  end

endmodule

// File: rtl/intc_line_cell.sv
module intc_line_cell
  import intc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic prev,
  input  logic edge_mode,
  input  logic pol,
  input  logic ack,
  output logic evt,
  output logic pend
);

  logic held_q;
  logic lvl;

  always_comb begin
    evt  = edge_hit(cur, prev, pol);
    lvl  = level_hit(cur, pol);
    pend = edge_mode ? held_q : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= latch_next(held_q, edge_mode, ack, evt);
  end

  AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && evt && ack) |=> held_q); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && ack && !evt) |=> !held_q); // R6
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && held_q && !ack) |=> held_q); // R5
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> !held_q); // R10

endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic [NUM_LINES-1:0] prev_in,
  input  logic                 wr_en,
  input  reg_sel_e             sel,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] rdata,
  output logic                 req_q
);

  logic [NUM_LINES-1:0] mask_q, mode_q, pol_q;
  logic [NUM_LINES-1:0] ack_vec, evt_vec, pend_vec, status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else if (wr_en) begin
      if (sel == REG_MASK) mask_q <= wdata;
      if (sel == REG_MODE) mode_q <= wdata;
      if (sel == REG_POL)  pol_q  <= wdata;
    end
  end

  assign ack_vec = (wr_en && sel == REG_CLR) ? wdata : '0;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    intc_line_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .cur       (line_in[i]),
      .prev      (prev_in[i]),
      .edge_mode (mode_q[i]),
      .pol       (pol_q[i]),
      .ack       (ack_vec[i]),
      .evt       (evt_vec[i]),
      .pend      (pend_vec[i])
    );
  end

  assign status = pend_vec & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= |status;
  end

  always_comb begin
    case (sel)
      REG_SRC:  rdata = pend_vec;
      REG_MASK: rdata = mask_q;
      REG_MODE: rdata = mode_q;
      REG_POL:  rdata = pol_q;
      REG_STS:  rdata = status;
      default:  rdata = '0;
    endcase
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mask_q) && $stable(mode_q) && $stable(pol_q))); // R9
  AST_REQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(status != '0)); // R8
  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !req_q); // R3
  AST_STATUS_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~pend_vec & ~mask_q & ~mode_q & ~pol_q) == '0); // R2

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BANK_SPAN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  output logic                 irq_req,
  output logic                 fiq_req
);

  logic                 dec_hit;
  logic                 dec_bank;
  reg_sel_e             dec_sel;
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] bank_rdata [BANK_COUNT];
  logic                 bank_req   [BANK_COUNT];
  logic                 bank_wr    [BANK_COUNT];

  intc_decode #(.ADDR_W(ADDR_W), .BANK_SPAN(BANK_SPAN)) u_dec (
    .addr (reg_addr),
    .hit  (dec_hit),
    .bank (dec_bank),
    .sel  (dec_sel)
  );

  intc_sampler #(.NUM_LINES(NUM_LINES)) u_smp (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (line_in),
    .prev_q  (prev_q)
  );

  for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
    assign bank_wr[b] = reg_wr && dec_hit && (dec_bank == 1'(b));
    intc_bank #(.NUM_LINES(NUM_LINES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_in),
      .prev_in (prev_q),
      .wr_en   (bank_wr[b]),
      .sel     (dec_sel),
      .wdata   (reg_wdata),
      .rdata   (bank_rdata[b]),
      .req_q   (bank_req[b])
    );
  end

  assign reg_rdata = dec_hit ? bank_rdata[dec_bank] : '0;
  assign irq_req   = bank_req[BANK_NORM];
  assign fiq_req   = bank_req[BANK_FAST];

  AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank_wr[BANK_FAST], bank_wr[BANK_NORM]})); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> (reg_rdata == '0)); // R2

endmodule

// File: tb/dual_bank_intc_tb.sv
`timescale 1ns/1ps
module dual_bank_intc_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] line_in = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req, fiq_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  dual_bank_intc u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req)
  );

  // Behavioural reference model.
  logic [31:0] m_en[2], m_sense[2], m_pol[2], m_latch[2];
  logic [31:0] m_last;
  logic        m_out[2];

  function automatic logic [31:0] m_raw(int b, logic [31:0] cur);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (m_sense[b][i]) r[i] = m_latch[b][i];
      else               r[i] = m_pol[b][i] ? !cur[i] : cur[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a, logic [31:0] cur);
    case (a)
      8'h00: return m_raw(0, cur);
      8'h04: return m_en[0];
      8'h0C: return m_sense[0];
      8'h10: return m_pol[0];
      8'h14: return m_raw(0, cur) & m_en[0];
      8'h20: return m_raw(1, cur);
      8'h24: return m_en[1];
      8'h2C: return m_sense[1];
      8'h30: return m_pol[1];
      8'h34: return m_raw(1, cur) & m_en[1];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [31:0] nl [2];
    logic [31:0] ack;
    logic        ev;
    int          base;
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        m_en[b] = 0; m_sense[b] = 0; m_pol[b] = 0; m_latch[b] = 0; m_out[b] = 0;
      end
      m_last = 0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        base = b * 32;
        m_out[b] = |(m_raw(b, line_in) & m_en[b]);
        ack = (reg_wr && reg_addr == 8'(base + 8)) ? reg_wdata : 32'h0;
        for (int i = 0; i < 32; i++) begin
          ev = m_pol[b][i] ? (line_in[i] && !m_last[i]) : (!line_in[i] && m_last[i]);
          if (m_sense[b][i]) nl[b][i] = (m_latch[b][i] && !ack[i]) || ev;
          else               nl[b][i] = 1'b0;
        end
      end
      for (int b = 0; b < 2; b++) begin
        base = b * 32;
        m_latch[b] = nl[b];
        if (reg_wr && reg_addr == 8'(base + 4))  m_en[b]    = reg_wdata;
        if (reg_wr && reg_addr == 8'(base + 12)) m_sense[b] = reg_wdata;
        if (reg_wr && reg_addr == 8'(base + 16)) m_pol[b]   = reg_wdata;
      end
      m_last = line_in;
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (irq_req !== m_out[0]) begin
        n_fail++;
        $display("FAIL R8 irq_req got %0b exp %0b at %0t", irq_req, m_out[0], $time);
      end
      n_tests++;
      if (fiq_req !== m_out[1]) begin
        n_fail++;
        $display("FAIL R8 fiq_req got %0b exp %0b at %0t", fiq_req, m_out[1], $time);
      end
      n_tests++;
      if (reg_rdata !== m_read(reg_addr, line_in)) begin
        n_fail++;
        $display("FAIL R2 read @%h got %h exp %h", reg_addr, reg_rdata, m_read(reg_addr, line_in));
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic drive(logic [31:0] v);
    @(negedge clk); #1;
    line_in = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1 reset state
    rd(8'h04, 0, "R1 norm enable"); rd(8'h0C, 0, "R1 norm sense");
    rd(8'h10, 0, "R1 norm pol");    rd(8'h24, 0, "R1 fast enable");
    rd(8'h00, 0, "R1 norm raw");    rd(8'h20, 0, "R1 fast raw");
    chk("R1 irq_req", 32'(irq_req), 0); chk("R1 fiq_req", 32'(fiq_req), 0);

    // R3/R4 level active-high
    wr(8'h04, 32'h8);
    drive(32'h8);
    rd(8'h00, 32'h8, "R4 level follows input");
    rd(8'h14, 32'h8, "R3 status enabled");
    rd(8'h34, 32'h0, "R9 fast bank not enabled");
    rd(8'h20, 32'h8, "R3 raw unmasked");
    step();
    chk("R8 irq_req rises", 32'(irq_req), 1);
    chk("R9 fiq_req quiet", 32'(fiq_req), 0);
    wr(8'h08, 32'h8);
    rd(8'h00, 32'h8, "R6 ack ignores level line");
    drive(32'h0);
    rd(8'h00, 32'h0, "R4 level not latched");
    step();
    chk("R8 irq_req falls", 32'(irq_req), 0);

    // R4 active-low
    wr(8'h10, 32'h20);
    rd(8'h00, 32'h20, "R4 active-low level");
    wr(8'h10, 32'h0);
    rd(8'h00, 32'h0, "R4 polarity restored");

    // R5 rising edge on fast bank line 7
    wr(8'h2C, 32'h80); wr(8'h30, 32'h80);
    drive(32'h80);
    rd(8'h20, 32'h0, "R5 not latched before edge");
    step();
    rd(8'h20, 32'h80, "R5 rising edge latched");
    drive(32'h0); step();
    rd(8'h20, 32'h80, "R5 latch sticky");
    rd(8'h00, 32'h0, "R4 normal bank level dropped");
    wr(8'h24, 32'h80); step();
    chk("R8 fiq_req from edge", 32'(fiq_req), 1);
    wr(8'h28, 32'h1);
    rd(8'h20, 32'h80, "R6 zero bits keep latch");
    wr(8'h28, 32'h80);
    rd(8'h20, 32'h0, "R6 one bit clears latch");
    step();
    chk("R8 fiq_req cleared", 32'(fiq_req), 0);

    // R5 falling edge on normal bank line 9
    wr(8'h0C, 32'h200);
    drive(32'h200); step();
    rd(8'h00, 32'h0, "R5 rising ignored in falling mode");
    drive(32'h0); step();
    rd(8'h00, 32'h200, "R5 falling edge latched");

    // R7 edge beats acknowledge on the same edge
    @(negedge clk); #1;
    line_in = 32'h80; reg_addr = 8'h28; reg_wdata = 32'h80; reg_wr = 1'b1;
    step(); reg_wr = 1'b0;
    rd(8'h20, 32'h80, "R7 edge wins over ack");

    // R10 level round trip discards latch
    drive(32'h0); step();
    wr(8'h0C, 32'h0);
    rd(8'h00, 32'h0, "R10 level view of line 9");
    wr(8'h0C, 32'h200);
    rd(8'h00, 32'h0, "R10 latch discarded");

    // R2 decode
    rd(8'h18, 0, "R2 gap reads zero"); rd(8'h40, 0, "R2 beyond banks");
    rd(8'h05, 0, "R2 misaligned");     rd(8'h08, 0, "R2 ack reads zero");
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h00, 32'hFFFF);
    wr(8'h44, 32'h0);         wr(8'h06, 32'h0);
    rd(8'h04, 32'h8, "R2 enable untouched");
    rd(8'h0C, 32'h200, "R2 sense untouched");
    rd(8'h24, 32'h80, "R9 fast enable untouched");

    // R3 enable all off
    wr(8'h04, 32'h0);
    drive(32'h8);
    rd(8'h14, 32'h0, "R3 status silenced");
    rd(8'h00, 32'h8, "R3 raw still visible");
    step(); step();
    chk("R3 irq_req silenced", 32'(irq_req), 0);
    drive(32'h0); step();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule